// File: doc/BRIEF.md
# Non-arithmetic double-to-single float converter

This block turns a 64-bit IEEE 754 double-precision operand into a 32-bit single-precision bit pattern. It moves and selects bits; it does no arithmetic. Nothing is rounded, no status is raised, and NaNs are never quieted, so a signaling NaN comes out still signaling and with its upper payload bits intact. Operands that sit below the single-precision normal range, including double-precision denormals, are shifted right into single-precision denormal form and their surplus low bits are dropped.

The converter accepts one operand per clock, qualified by a valid strobe. One clock later it presents the 32-bit pattern copied into both halves of a 64-bit result word, together with a one-cycle valid strobe. Exponents too large for single precision are not saturated: the result carries the selected exponent bits as they are.

Top module: `nonarith_dp2sp`

## Requirements
- R1: For an operand with biased exponent e (in_data[62:52]) of at least 897, the 32-bit result has bit 31 = in_data[63], bit 30 = e[10], bits 29:23 = e[6:0], and bits 22:0 = in_data[51:29]; in_data[28:0] are dropped without rounding.
- R2: An operand with e = 0 and a nonzero stored fraction (a double denormal) produces a single-precision zero with the operand's sign.
- R3: For 1 <= e <= 896, the working significand {1, in_data[51:0]} (53 bits) is shifted right by 897 - e, result bits 22:0 take bits 51:29 of the shifted value and result bits 30:23 are all zero; when 897 - e exceeds 63 the fraction is zero.
- R4: An operand with e = 0 and a zero fraction produces a zero of the same sign (0x00000000 or 0x80000000).
- R5: An operand with e = 2047 (infinity or NaN) produces result bits 30:23 all ones and bits 22:0 = in_data[51:29], so a NaN's quiet bit (bit 22) is copied and never forced to one.
- R6: Large exponents are not saturated: for e from 1152 to 2046 the result exponent field is {e[10], e[6:0]} even where that differs from the true value.
- R7: out_data[63:32] and out_data[31:0] always hold the same 32-bit result.
- R8: out_valid is high in exactly the cycle after each cycle with in_valid high, low otherwise, and out_data holds its last value while in_valid is low.
- R9: A synchronous active-high rst clears out_valid and out_data to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand qualifier |
| in_data | input | 64 | Double-precision operand |
| out_valid | output | 1 | Result qualifier, one cycle per operand |
| out_data | output | 64 | Single-precision result in both 32-bit halves |

## Verification
On every cycle the assertions check the valid timing and data hold, the replication of the two halves, the passage of the sign, the all-ones exponent and copied payload for infinities and NaNs, and the zero exponent field for tiny operands. The exact fraction of a denormalized result, the truncation of low bits, the shift boundary at 63, signed zeros and the unsaturated large exponents are shown only by the bench's scenarios, which compare every result against a model of the bit rules.

// File: rtl/nonarith_dp2sp_pkg.sv
package nonarith_dp2sp_pkg;

    localparam int DP_W      = 64;
    localparam int DP_EXP_W  = 11;
    localparam int DP_FRAC_W = 52;
    localparam int SP_W      = 32;
    localparam int SP_EXP_W  = 8;
    localparam int SP_FRAC_W = 23;

    // working significand carries the implicit leading bit
    localparam int WORK_W    = DP_FRAC_W + 1;
    // first exponent that still maps to a single-precision normal
    localparam int TINY_EDGE = 897;
    // exponent assigned to tiny values after denormalization
    localparam int TINY_EXP  = TINY_EDGE - 1;
    // beyond this shift distance the fraction is forced to zero
    localparam int SHIFT_MAX = 63;
    localparam int AMT_W     = DP_EXP_W + 1;
    localparam int REPL      = DP_W / SP_W;

    typedef struct packed {
        logic                 sign;
        logic [DP_EXP_W-1:0]  exp;
        logic [WORK_W-1:0]    frac;
    } work_t;

endpackage

// File: rtl/nonarith_dp2sp_unpack.sv
module nonarith_dp2sp_unpack
    import nonarith_dp2sp_pkg::*;
(
    input  logic [DP_W-1:0] operand,
    output work_t           fields
);

    logic [DP_EXP_W-1:0]  raw_exp;
    logic [DP_FRAC_W-1:0] raw_frac;
    logic                 exp_zero;
    logic                 is_denorm;

    always_comb begin
        raw_exp   = operand[DP_W-2 -: DP_EXP_W];
        raw_frac  = operand[DP_FRAC_W-1:0];
        exp_zero  = (raw_exp == '0);
        is_denorm = exp_zero && (raw_frac != '0);

        fields.sign = operand[DP_W-1];
        // implicit one only for nonzero exponents; zero stays all-zero
        fields.frac = {~exp_zero, raw_frac};
        // a denormal is treated as having the smallest normal exponent
        if (is_denorm) begin
            fields.exp = DP_EXP_W'(1);
        end else begin
            fields.exp = raw_exp;
        end
    end

endmodule

// File: rtl/nonarith_dp2sp_tiny.sv
module nonarith_dp2sp_tiny
    import nonarith_dp2sp_pkg::*;
(
    input  work_t fields_in,
    output work_t fields_out
);

    logic             is_tiny;
    logic [AMT_W-1:0] amt;

    always_comb begin
        is_tiny = (fields_in.exp < DP_EXP_W'(TINY_EDGE)) && (fields_in.frac != '0);
        amt     = AMT_W'(TINY_EDGE) - {1'b0, fields_in.exp};

        fields_out = fields_in;
        if (is_tiny) begin
            if (amt > AMT_W'(SHIFT_MAX)) begin
                fields_out.frac = '0;
            end else begin
                fields_out.frac = fields_in.frac >> amt;
            end
            fields_out.exp = DP_EXP_W'(TINY_EXP);
        end
    end

endmodule

// File: rtl/nonarith_dp2sp_pack.sv
module nonarith_dp2sp_pack
    import nonarith_dp2sp_pkg::*;
(
    input  work_t           fields,
    output logic [SP_W-1:0] word
);

    always_comb begin
        word = {fields.sign,
                fields.exp[DP_EXP_W-1],
                fields.exp[SP_EXP_W-2:0],
                fields.frac[DP_FRAC_W-1 -: SP_FRAC_W]};
    end

endmodule

// File: rtl/nonarith_dp2sp.sv
module nonarith_dp2sp
    import nonarith_dp2sp_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [DP_W-1:0] in_data,
    output logic            out_valid,
    output logic [DP_W-1:0] out_data
);

    typedef struct packed {
        logic            vld;
        logic [DP_W-1:0] data;
    } state_t;

    state_t           st_d, st_q;
    work_t            unpacked;
    work_t            shaped;
    logic [SP_W-1:0]  word;
    logic [DP_W-1:0]  repl_word;

    nonarith_dp2sp_unpack u_unpack (
        .operand (in_data),
        .fields  (unpacked)
    );

    nonarith_dp2sp_tiny u_tiny (
        .fields_in  (unpacked),
        .fields_out (shaped)
    );

    nonarith_dp2sp_pack u_pack (
        .fields (shaped),
        .word   (word)
    );

    for (genvar g = 0; g < REPL; g++) begin : g_repl
        assign repl_word[g*SP_W +: SP_W] = word;
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.data = repl_word;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign out_data  = st_q.data;

endmodule

// File: rtl/nonarith_dp2sp_chk.sv
module nonarith_dp2sp_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [63:0] in_data,
    input logic        out_valid,
    input logic [63:0] out_data
);

    a_r9_reset_clear: assert property (@(posedge clk)
        rst |=> (!out_valid && out_data == 64'h0));

    a_r8_valid_next: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_data));

    a_r7_replicate: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_data[63:32] == out_data[31:0]));

    a_r1_sign: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (out_data[31] == $past(in_data[63])));

    a_r5_special_exp: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_data[62:52] == 11'h7FF) |=> (out_data[30:23] == 8'hFF));

    a_r5_payload: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_data[62:52] == 11'h7FF) |=> (out_data[22:0] == $past(in_data[51:29])));

    a_r3_tiny_exp: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_data[62:52] < 11'd897) |=> (out_data[30:23] == 8'h00));

endmodule

bind nonarith_dp2sp nonarith_dp2sp_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/nonarith_dp2sp_tb.sv
`timescale 1ns/1ps
module nonarith_dp2sp_tb;

    typedef struct {
        logic [63:0] exp_data;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [63:0] in_data = '0;
    logic        out_valid;
    logic [63:0] out_data;

    item_t       sb[$];
    int          checks = 0;
    int          fails  = 0;
    logic [63:0] last_exp = '0;

    always #2.5 clk = ~clk;

    nonarith_dp2sp u_dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    function automatic logic [31:0] model(input logic [63:0] x);
        logic        s;
        int          e;
        logic [52:0] m;
        int          sh;
        s = x[63];
        e = int'(x[62:52]);
        if (e == 0) begin
            return {s, 31'h0};
        end
        if (e < 897) begin
            sh = 897 - e;
            m  = {1'b1, x[51:0]};
            if (sh > 63) m = '0;
            else         m = m >> sh;
            return {s, 8'h00, m[51:29]};
        end
        return {s, x[62], x[58:52], x[51:29]};
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp_v);
        checks++;
        if (act !== exp_v) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp_v);
        end
    endtask

    task automatic drive(input logic [63:0] x, input string tag);
        item_t it;
        @(negedge clk);
        in_valid    = 1'b1;
        in_data     = x;
        it.exp_data = {model(x), model(x)};
        it.tag      = tag;
        sb.push_back(it);
        last_exp    = it.exp_data;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_data  = 64'hDEAD_BEEF_0123_4567;
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    // monitor: pops the oldest expected item whenever a result appears
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (sb.size() == 0) begin
                check("R8 unexpected out_valid", {63'h0, out_valid}, 64'h0);
            end else begin
                item_t it;
                it = sb.pop_front();
                check(it.tag, out_data, it.exp_data);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual running expected done");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R9 reset out_valid", {63'h0, out_valid}, 64'h0);
        check("R9 reset out_data", out_data, 64'h0);
        rst = 1'b0;
        idle(2);
        check("R8 idle out_valid", {63'h0, out_valid}, 64'h0);

        // R1 normal values and truncation
        drive(64'h3FF0_0000_0000_0000, "R1 one");
        idle(1);
        drive(64'hC004_0000_0000_0000, "R1 minus 2.5");
        drive(64'h3FF0_0000_3FFF_FFFF, "R1 truncation");
        drive(64'h4059_1EB8_51EB_851F, "R1 generic");
        // R2 double denormals
        drive(64'h0000_0000_0000_0001, "R2 min denormal");
        drive(64'h800F_FFFF_FFFF_FFFF, "R2 neg max denormal");
        // R3 tiny values
        drive(64'h3800_0000_0000_0000, "R3 shift 1");
        drive(64'hB80F_FFFF_E000_0000, "R3 neg shift 1 payload");
        drive(64'h36A0_0000_0000_0000, "R3 shift 23");
        drive(64'h3620_0000_0000_0000, "R3 shift 31");
        drive(64'h3420_0000_0000_0000, "R3 shift 63");
        drive(64'hB410_0000_0000_0000, "R3 shift 64");
        drive(64'h0010_0000_0000_0000, "R3 min normal");
        // R4 zeros
        drive(64'h0000_0000_0000_0000, "R4 plus zero");
        drive(64'h8000_0000_0000_0000, "R4 minus zero");
        // R5 infinities and NaNs
        drive(64'h7FF0_0000_0000_0000, "R5 plus inf");
        drive(64'hFFF0_0000_0000_0000, "R5 minus inf");
        drive(64'h7FF8_0000_0000_0000, "R5 quiet nan");
        drive(64'h7FF0_0000_2000_0000, "R5 signaling nan");
        drive(64'hFFF5_5555_5555_5555, "R5 signaling nan payload");
        // R6 unsaturated large exponents
        drive(64'h4B00_0000_0000_0000, "R6 exp 1200");
        drive(64'h7FEF_FFFF_FFFF_FFFF, "R6 max finite");
        drive(64'h47F0_0000_0000_0000, "R6 exp 1151");
        idle(2);

        // R8 hold: data kept while idle
        check("R8 hold out_valid", {63'h0, out_valid}, 64'h0);
        check("R8 hold out_data", out_data, last_exp);
        check("R7 halves equal", {32'h0, out_data[63:32]}, {32'h0, out_data[31:0]});
        check("R8 queue drained", 64'(sb.size()), 64'h0);

        // R9 reset mid-run
        @(negedge clk);
        rst = 1'b1;
        idle(2);
        check("R9 rerun reset out_data", out_data, 64'h0);
        rst = 1'b0;
        idle(2);

        summary();
        $finish;
    end

endmodule